// File: doc/BRIEF.md
# Pushbutton and Power-Fail Reset Sequencer

This block controls a reset line that is active low and open drain, and that same line also serves as the input from a pushbutton. The block sees the line only as a sampled level, `lineIn`. It pulls the line down by asserting `pullLow`. When the block is idle and a button press pulls the line low, the block drives the line low itself for a debounce window. After that window it stops driving and lets its own drive clear the input synchronizer. It then reads the real level. If the button is still held, the block waits for the release and then emits a reset pulse of fixed length. If the line is already high, the block returns to idle and issues no pulse.

A separate power-fail flag overrides the pushbutton sequence in every state. While the flag is high the line is held low. When the flag drops, the block keeps the line low for a recovery window if the oscillator-running flag is set. If the oscillator is stopped, the line is released at once. All windows are counted in enables from the `tick` input, nominally one per millisecond, and each window is 250 ticks by default. The power-fail and oscillator flags are expected to be synchronous to `clk`. The line level passes through a synchronizer of `SYNC_STAGES` flops, two by default.

Top module: `line_reset_seq`

## Requirements
- R1: After `rstN` is deasserted, `pullLow` is 0 and the block is idle, watching for a press.
- R2: When the block is idle and the line falls, `pullLow` goes to 1 at the third clock edge after the first edge that samples the line low. It stays 1 for `DEBOUNCE_TICKS` ticks.
- R3: When the debounce window ends, the block releases the line. It waits until its own drive has passed through the synchronizer, then reads the level. A high level returns the block to idle with no pulse. With the defaults and one tick per clock, a press that is low on at most `DEBOUNCE_TICKS`+3 sampling edges gives no pulse.
- R4: If the level was low at that read, the block waits for the line to go high. `pullLow` then goes to 1 at the third edge after the first edge that samples the line high. It stays 1 for `PULSE_TICKS` ticks, and then the block returns to idle.
- R5: Line lows caused by the block's own drive are never taken as a new press. Each press gives exactly one debounce window and at most one pulse.
- R6: Whenever `powerFail` is sampled 1, `pullLow` is 1 after that edge. This holds in every state.
- R7: When `powerFail` is sampled 0 after a power fail while `oscRunning` is 1, `pullLow` stays 1 for `RECOVER_TICKS` more ticks.
- R8: When `powerFail` is sampled 0 while `oscRunning` is 0, `pullLow` is 0 right after that edge.
- R9: A timed window ends at the clock edge that carries its Nth tick after entry. A tick on the entry edge itself does not count.
- R10: A power fail during any pushbutton phase abandons that sequence. After recovery the block is idle and issues no pulse for the interrupted press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineIn | input | 1 | Sampled level of the shared reset/button line (1 = high) |
| powerFail | input | 1 | Supply below threshold, synchronous to clk |
| oscRunning | input | 1 | Timekeeping oscillator is running |
| tick | input | 1 | Time base enable, one cycle per tick |
| pullLow | output | 1 | Enable of the open-drain pull-down on the line |

## Verification
A wrong state in this block shows at the ports as an edge of `pullLow` that comes too early, too late, or is missing. A shortened or stretched window shows by the end of that window. A bad decision after the settle phase shows within `SYNC_STAGES`+1 cycles, as a pulse that should not be there or as a missing pulse after the release. A power-fail override that does not take effect shows one edge after `powerFail` rises. Because of this, the bench compares the whole `pullLow` trace of each scenario, cycle by cycle, with an expected trace computed from press length, power-fail length, oscillator state and tick pattern.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEBOUNCE,
    ST_SETTLE,
    ST_WAIT_REL,
    ST_PULSE,
    ST_PFAIL,
    ST_RECOVER
  } seqState_t;

  typedef enum logic [1:0] {
    DUR_DEBOUNCE,
    DUR_PULSE,
    DUR_RECOVER
  } durSel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic    load;
    durSel_t sel;
    logic    drive;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic fallEdge;
    logic lineHigh;
    logic maskBusy;
    logic expire;
  } dpStatus_t;

endpackage

// File: rtl/lrs_datapath.sv
module lrs_datapath
  import lrs_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int DEBOUNCE_TICKS = 250,
  parameter int PULSE_TICKS    = 250,
  parameter int RECOVER_TICKS  = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineIn,
  input  logic        tick,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int MAX_A     = (DEBOUNCE_TICKS > PULSE_TICKS) ? DEBOUNCE_TICKS : PULSE_TICKS;
  localparam int MAX_TICKS = (MAX_A > RECOVER_TICKS) ? MAX_A : RECOVER_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [SYNC_STAGES-1:0] ownQ;
  logic                   lvlPrevQ;
  logic                   lineSeen;
  logic [CNT_W-1:0]       cntQ;
  logic [CNT_W-1:0]       loadVal;

  // Line synchronizer, with a matching pipe that tracks the block's own drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      ownQ  <= '0;
    end else begin
      for (int i = SYNC_STAGES - 1; i > 0; i--) begin
        syncQ[i] <= syncQ[i-1];
        ownQ[i]  <= ownQ[i-1];
      end
      syncQ[0] <= lineIn;
      ownQ[0]  <= strobe.drive;
    end
  end

  // A low that the block caused itself reads as high
  assign lineSeen = syncQ[SYNC_STAGES-1] | ownQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlPrevQ <= 1'b1;
    else       lvlPrevQ <= lineSeen;
  end

  // Window length selected by the control
  always_comb begin
    unique case (strobe.sel)
      DUR_DEBOUNCE: loadVal = CNT_W'(DEBOUNCE_TICKS);
      DUR_PULSE:    loadVal = CNT_W'(PULSE_TICKS);
      default:      loadVal = CNT_W'(RECOVER_TICKS);
    endcase
  end

  // One shared down counter, decremented by tick enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.load) begin
      cntQ <= loadVal;
    end else if (tick && (cntQ != '0)) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign status.fallEdge = lvlPrevQ & ~lineSeen;
  assign status.lineHigh = lineSeen;
  assign status.maskBusy = |ownQ;
  assign status.expire   = tick && (cntQ == CNT_W'(1));

endmodule

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerFail,
  input  logic        oscRunning,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output seqState_t   stateQ
);

  seqState_t stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:     if (status.fallEdge) stateD = ST_DEBOUNCE;
      ST_DEBOUNCE: if (status.expire) stateD = ST_SETTLE;
      ST_SETTLE:   if (!status.maskBusy) stateD = status.lineHigh ? ST_IDLE : ST_WAIT_REL;
      ST_WAIT_REL: if (status.lineHigh) stateD = ST_PULSE;
      ST_PULSE:    if (status.expire) stateD = ST_IDLE;
      ST_PFAIL:    stateD = oscRunning ? ST_RECOVER : ST_IDLE;
      ST_RECOVER:  if (status.expire) stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
    // power fail overrides every phase
    if (powerFail) stateD = ST_PFAIL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.load = 1'b0;
    strobe.sel  = DUR_DEBOUNCE;
    if (stateD != stateQ) begin
      unique case (stateD)
        ST_DEBOUNCE: begin strobe.load = 1'b1; strobe.sel = DUR_DEBOUNCE; end
        ST_PULSE:    begin strobe.load = 1'b1; strobe.sel = DUR_PULSE;    end
        ST_RECOVER:  begin strobe.load = 1'b1; strobe.sel = DUR_RECOVER;  end
        default:     strobe.load = 1'b0;
      endcase
    end
    strobe.drive = (stateQ == ST_DEBOUNCE) || (stateQ == ST_PULSE) ||
                   (stateQ == ST_PFAIL)    || (stateQ == ST_RECOVER);
  end

endmodule

// File: rtl/line_reset_seq.sv
module line_reset_seq
  import lrs_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int DEBOUNCE_TICKS = 250,
  parameter int PULSE_TICKS    = 250,
  parameter int RECOVER_TICKS  = 250
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic powerFail,
  input  logic oscRunning,
  input  logic tick,
  output logic pullLow
);

  ctrlStrobe_t ctrlStrobe;
  dpStatus_t   dpStatus;
  seqState_t   ctrlState;

  lrs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerFail  (powerFail),
    .oscRunning (oscRunning),
    .status     (dpStatus),
    .strobe     (ctrlStrobe),
    .stateQ     (ctrlState)
  );

  lrs_datapath #(
    .SYNC_STAGES    (SYNC_STAGES),
    .DEBOUNCE_TICKS (DEBOUNCE_TICKS),
    .PULSE_TICKS    (PULSE_TICKS),
    .RECOVER_TICKS  (RECOVER_TICKS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .tick   (tick),
    .strobe (ctrlStrobe),
    .status (dpStatus)
  );

  assign pullLow = ctrlStrobe.drive;

endmodule

// File: rtl/lrs_checker.sv
module lrs_checker
  import lrs_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      powerFail,
  input logic      oscRunning,
  input logic      pullLow,
  input logic      maskBusy,
  input seqState_t state
);

  AST_PF_FORCES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> pullLow) else $error("power fail did not pull the line low"); // R6

  AST_DEBOUNCE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEBOUNCE && $past(state) != ST_DEBOUNCE) |-> $past(state) == ST_IDLE)
    else $error("debounce entered from a non-idle phase"); // R2

  AST_SETTLE_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE && maskBusy && !powerFail) |=> state == ST_SETTLE)
    else $error("level read before own drive drained"); // R3

  AST_PULSE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE && $past(state) != ST_PULSE) |-> $past(state) == ST_WAIT_REL)
    else $error("pulse started without a release wait"); // R4

  AST_RECOVER_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PFAIL && !powerFail && oscRunning) |=> (state == ST_RECOVER && pullLow))
    else $error("recovery window skipped with oscillator running"); // R7

  AST_NOOSC_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PFAIL && !powerFail && !oscRunning) |=> !pullLow)
    else $error("line held with oscillator stopped"); // R8

  AST_RECOVER_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER) |=> (state == ST_RECOVER || state == ST_IDLE || state == ST_PFAIL))
    else $error("recovery resumed a pushbutton phase"); // R10

endmodule

bind line_reset_seq lrs_checker u_lrsChecker (
  .clk        (clk),
  .rstN       (rstN),
  .powerFail  (powerFail),
  .oscRunning (oscRunning),
  .pullLow    (pullLow),
  .maskBusy   (dpStatus.maskBusy),
  .state      (ctrlState)
);

// File: tb/test_line_reset_seq.sv
`timescale 1ns/1ps
module test_line_reset_seq;

  localparam int DEB = 6;
  localparam int PUL = 5;
  localparam int REC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic btnDown = 1'b0;
  logic powerFail = 1'b0;
  logic oscRunning = 1'b1;
  logic tick = 1'b1;
  logic pullLow;
  logic lineIn;

  int checks = 0;
  int errors = 0;

  // scenario settings
  int mode = 0;       // 0 press, 1 power fail, 2 power fail inside press
  int hold = 0;
  int pfLen = 0;
  int pfStart = 0;
  bit slowTick = 1'b0;

  assign lineIn = ~(pullLow | btnDown);

  always #2 clk = ~clk;

  line_reset_seq #(
    .SYNC_STAGES    (2),
    .DEBOUNCE_TICKS (DEB),
    .PULSE_TICKS    (PUL),
    .RECOVER_TICKS  (REC)
  ) i_line_reset_seq (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineIn),
    .powerFail  (powerFail),
    .oscRunning (oscRunning),
    .tick       (tick),
    .pullLow    (pullLow)
  );

  function automatic bit tickAt(int p);
    return slowTick ? (p % 3 == 0) : 1'b1;
  endfunction

  // last sample index with the line held after a power fail (R7 R8 R9)
  function automatic int recEnd();
    int cnt = 0;
    if (!oscRunning) return pfLen;
    for (int p = pfLen + 2; p < pfLen + 200; p++) begin
      if (tickAt(p)) cnt++;
      if (cnt == REC) return p - 1;
    end
    return -1;
  endfunction

  function automatic bit expPull(int k);
    int dEnd;
    case (mode)
      0: return (k >= 3 && k <= DEB + 2) ||
                (hold >= DEB + 4 && k >= hold + 3 && k <= hold + 2 + PUL);
      1: return (k >= 1 && k <= recEnd());
      default: begin
        dEnd = (DEB + 2 < pfStart) ? DEB + 2 : pfStart;
        return (k >= 3 && k <= dEnd) || (k >= pfStart + 1 && k <= pfStart + pfLen + REC);
      end
    endcase
  endfunction

  function automatic bit btnAt(int k);
    case (mode)
      0: return k < hold;
      1: return 1'b0;
      default: return k < pfStart + 3;
    endcase
  endfunction

  function automatic bit pfAt(int k);
    case (mode)
      0: return 1'b0;
      1: return k < pfLen;
      default: return k >= pfStart && k < pfStart + pfLen;
    endcase
  endfunction

  task automatic runTrace(input string tag, input int len);
    bit bad = 1'b0;
    int badK = 0;
    logic badAct = 1'b0;
    bit badExp = 1'b0;
    for (int k = 0; k <= len; k++) begin
      if (!bad && (pullLow !== expPull(k))) begin
        bad = 1'b1; badK = k; badAct = pullLow; badExp = expPull(k);
      end
      btnDown   = btnAt(k);
      powerFail = pfAt(k);
      tick      = tickAt(k + 1);
      @(negedge clk);
    end
    btnDown = 1'b0; powerFail = 1'b0; tick = 1'b1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s mode=%0d hold=%0d pfLen=%0d sample=%0d actual=%0b expected=%0b",
               tag, mode, hold, pfLen, badK, badAct, badExp);
    end
  endtask

  task automatic doPress(input int h);
    mode = 0; hold = h; slowTick = 1'b0;
    if (h >= DEB + 4) runTrace("R2 R4 R5 long press", ((h > DEB + 6) ? h : DEB + 6) + PUL + 8);
    else              runTrace("R2 R3 R5 short press", DEB + PUL + 14);
  endtask

  task automatic doPf(input int l, input bit osc, input bit slow);
    mode = 1; pfLen = l; oscRunning = osc; slowTick = slow;
    if (slow)     runTrace("R7 R9 slow tick recovery", recEnd() + 8);
    else if (osc) runTrace("R6 R7 power fail recovery", recEnd() + 8);
    else          runTrace("R6 R8 power fail no oscillator", recEnd() + 8);
    oscRunning = 1'b1; slowTick = 1'b0;
  endtask

  task automatic doPrio(input int at, input int l);
    mode = 2; pfStart = at; pfLen = l; oscRunning = 1'b1; slowTick = 1'b0;
    runTrace("R10 R6 power fail inside press", at + l + REC + 12);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int r;
    void'($urandom(32'd4177));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (pullLow !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state actual=%0b expected=0", pullLow);
    end

    // directed corners
    doPress(1);
    doPress(DEB + 3);        // R3 boundary: no pulse
    doPress(DEB + 4);        // R4 boundary: pulse
    doPress(DEB + 15);
    doPf(3, 1'b1, 1'b0);
    doPf(7, 1'b0, 1'b0);
    doPf(1, 1'b1, 1'b0);
    doPf(5, 1'b1, 1'b1);     // R9 tick every third cycle
    doPf(4, 1'b1, 1'b1);
    doPrio(DEB + 10, 6);     // during release wait
    doPrio(4, 8);            // during debounce

    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      r = $urandom_range(0, 3);
      case (r)
        0: doPress($urandom_range(1, DEB + 3));
        1: doPress($urandom_range(DEB + 4, DEB + 25));
        2: doPf($urandom_range(1, 20), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        default: doPrio($urandom_range(DEB + 8, DEB + 14), $urandom_range(1, 10));
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule